// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block shapes the second operand of a data-processing unit. In shift mode it takes a word and moves it left or right, either logically, arithmetically or as a rotation, by an amount. The amount comes either from a five-bit immediate field or from the low byte of a register. Alongside the shifted word it produces the carry-out that a flag update would take. The zero-amount encodings have their own meanings. An immediate logical right by zero means a shift by the full word. An immediate rotate by zero means a one-bit rotate through the carry.

In immediate mode the block builds a constant instead. It zero-extends an eight-bit value and rotates it right by twice a four-bit rotation field. Both results pass through one output register, so a result appears on the outputs one clock after its inputs are presented. The decode that supplies the fields, the ALU that consumes the operand and the flag register are outside the block.

Shift type encoding on `kind_i`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right.

Top module: `opshift_unit`

## Requirements
- R1: While `rst` is high, `result_o` and `carry_o` are cleared at each rising edge. Otherwise the outputs take, one clock later, the value computed from the inputs present at the edge.
- R2: With a nonzero effective amount n below 32, the result is the input moved left by n (kind 0), right with zero fill (kind 1), right with sign fill (kind 2), or rotated right by n (kind 3).
- R3: With an effective amount n from 1 to 31, the carry-out is input bit 32−n for logical left, and input bit n−1 for the other three kinds.
- R4: With an effective amount of zero and kind 0 or kind 2, the result equals the input and the carry-out equals `carry_i`, whichever source the amount came from.
- R5: With an effective amount of zero and kind 1, the carry-out is input bit 31. The result is zero for an immediate amount and the unchanged input for a register amount.
- R6: With an effective amount of zero and kind 3, an immediate amount gives {`carry_i`, input[31:1]} with carry-out input bit 0. A register amount gives the unchanged input with carry-out `carry_i`.
- R7: When `amt_from_reg_i` is low, only `amt_i[4:0]` forms the amount; `amt_i[7:5]` has no effect on either output.
- R8: For a register amount of exactly 32, logical left gives zero with carry input bit 0, and logical right gives zero with carry input bit 31. Amounts above 32 give zero with carry 0 for both kinds.
- R9: For a register amount of 32 or more, arithmetic right gives every bit equal to input bit 31, and the carry-out equals input bit 31.
- R10: For a register rotate amount of 32 or more, the rotation is by the amount modulo 32 and the carry-out is the result's bit 31. A nonzero multiple of 32 leaves the input unchanged with carry input bit 31.
- R11: With `imm_mode_i` high, the result is `imm_byte_i` zero-extended and rotated right by 2×`imm_rot_i`. The carry-out is `carry_i` when `imm_rot_i` is 0 and the result's bit 31 otherwise. The shift-mode inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imm_mode_i | input | 1 | 1 selects immediate constant expansion, 0 selects shifting |
| opnd_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_i | input | 8 | Shift amount (low 5 bits only when immediate) |
| amt_from_reg_i | input | 1 | 1 when the amount came from a register |
| carry_i | input | 1 | Current carry flag |
| imm_byte_i | input | 8 | Constant to expand in immediate mode |
| imm_rot_i | input | 4 | Rotation field; rotation is twice this value |
| result_o | output | 32 | Registered shifted or expanded operand |
| carry_o | output | 1 | Registered carry-out |

## Verification
The checker relates each output to the inputs of the previous cycle. It therefore assumes that the inputs settle before every rising edge and that a cycle with reset high is never compared. The stimulus changes the inputs only at falling edges and holds them for a whole cycle. The shift sweep covers every kind, both amount sources, all 256 amount codes and four contrasting words with both carry values, so immediate codes with the upper bits set reach the R7 cases. The expansion sweep drives the shift inputs with unrelated values to show that they are ignored.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/opshift_core.sv
module opshift_core
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] v,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              from_reg,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [AMT_W-1:0]  n;
  logic [AMT_W-1:0]  n_clamp;
  logic [SH_W-1:0]   rot;
  logic [DATA_W:0]   ext;

  // immediate amounts carry only SH_W meaningful bits
  assign n       = from_reg ? amt : AMT_W'(amt[SH_W-1:0]);
  assign n_clamp = (n > FULL) ? FULL : n;
  assign rot     = n[SH_W-1:0];

  always_comb begin
    res  = v;
    cout = cin;
    ext  = '0;
    unique case (kind)
      SH_LSL: begin
        if (n != '0) begin
          ext  = {1'b0, v} << n;
          res  = ext[DATA_W-1:0];
          cout = ext[DATA_W];
        end
      end
      SH_LSR: begin
        if (n == '0) begin
          cout = v[DATA_W-1];
          if (!from_reg) res = '0;
        end else begin
          ext  = {v, 1'b0} >> n;
          res  = ext[DATA_W:1];
          cout = ext[0];
        end
      end
      SH_ASR: begin
        if (n != '0) begin
          ext  = $signed({v, 1'b0}) >>> n_clamp;
          res  = ext[DATA_W:1];
          cout = ext[0];
        end
      end
      SH_ROR: begin
        if (n == '0) begin
          if (!from_reg) begin
            res  = {cin, v[DATA_W-1:1]};
            cout = v[0];
          end
        end else begin
          res  = DATA_W'({v, v} >> rot);
          cout = res[DATA_W-1];
        end
      end
    endcase
  end
endmodule

// File: rtl/opshift_immexp.sv
module opshift_immexp #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ROT_W-1:0]  rot_in,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int RAMT_W = ROT_W + 1;

  logic [DATA_W-1:0] base;
  logic [RAMT_W-1:0] ramt;

  assign base = DATA_W'(byte_in);
  assign ramt = {rot_in, 1'b0};
  assign res  = DATA_W'({base, base} >> ramt);
  assign cout = (rot_in == '0) ? cin : res[DATA_W-1];
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imm_mode_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              amt_from_reg_i,
  input  logic              carry_i,
  input  logic [BYTE_W-1:0] imm_byte_i,
  input  logic [ROT_W-1:0]  imm_rot_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  logic [DATA_W-1:0] sh_res, ix_res;
  logic              sh_c, ix_c;

  opshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) core_i (
    .v(opnd_i), .kind(shift_kind_e'(kind_i)), .amt(amt_i),
    .from_reg(amt_from_reg_i), .cin(carry_i), .res(sh_res), .cout(sh_c)
  );

  opshift_immexp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)) immexp_i (
    .byte_in(imm_byte_i), .rot_in(imm_rot_i), .cin(carry_i),
    .res(ix_res), .cout(ix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= imm_mode_i ? ix_res : sh_res;
      carry_o  <= imm_mode_i ? ix_c : sh_c;
    end
  end
endmodule

// File: rtl/opshift_unit_chk.sv
module opshift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int BYTE_W = 8,
  parameter int ROT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              imm_mode_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [1:0]        kind_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic              amt_from_reg_i,
  input logic              carry_i,
  input logic [BYTE_W-1:0] imm_byte_i,
  input logic [ROT_W-1:0]  imm_rot_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic zero_amt, big_amt;
  assign zero_amt = amt_from_reg_i ? (amt_i == '0) : (amt_i[SH_W-1:0] == '0);
  assign big_amt  = amt_from_reg_i && (amt_i >= AMT_W'(DATA_W));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result_o == '0) && !carry_o); // R1

  AST_ZERO_LSL_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!imm_mode_i && kind_i == 2'd0 && zero_amt))
    |-> (result_o == $past(opnd_i)) && (carry_o == $past(carry_i))); // R4

  AST_ZERO_LSR_IMM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!imm_mode_i && kind_i == 2'd1 && zero_amt && !amt_from_reg_i))
    |-> (result_o == '0) && (carry_o == $past(opnd_i[DATA_W-1]))); // R5

  AST_ZERO_ROR_RRX: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!imm_mode_i && kind_i == 2'd3 && zero_amt && !amt_from_reg_i))
    |-> (result_o == {$past(carry_i), $past(opnd_i[DATA_W-1:1])})
        && (carry_o == $past(opnd_i[0]))); // R6

  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!imm_mode_i && kind_i == 2'd2 && big_amt))
    |-> (result_o == {DATA_W{$past(opnd_i[DATA_W-1])}})
        && (carry_o == $past(opnd_i[DATA_W-1]))); // R9

  AST_IMM_NO_ROT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(imm_mode_i && imm_rot_i == '0))
    |-> (result_o == DATA_W'($past(imm_byte_i))) && (carry_o == $past(carry_i))); // R11
endmodule

bind opshift_unit opshift_unit_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .BYTE_W(BYTE_W), .ROT_W(ROT_W)
) chk_i (
  .clk(clk), .rst(rst), .imm_mode_i(imm_mode_i), .opnd_i(opnd_i),
  .kind_i(kind_i), .amt_i(amt_i), .amt_from_reg_i(amt_from_reg_i),
  .carry_i(carry_i), .imm_byte_i(imm_byte_i), .imm_rot_i(imm_rot_i),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/opshift_unit_tb.sv
module opshift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imm_mode_i = 1'b0;
  logic [31:0] opnd_i = 32'h0;
  logic [1:0]  kind_i = 2'd0;
  logic [7:0]  amt_i = 8'h0;
  logic        amt_from_reg_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [7:0]  imm_byte_i = 8'h0;
  logic [3:0]  imm_rot_i = 4'h0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  opshift_unit dut_i (
    .clk(clk), .rst(rst), .imm_mode_i(imm_mode_i), .opnd_i(opnd_i),
    .kind_i(kind_i), .amt_i(amt_i), .amt_from_reg_i(amt_from_reg_i),
    .carry_i(carry_i), .imm_byte_i(imm_byte_i), .imm_rot_i(imm_rot_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected shift behaviour, bit by bit from the requirements
  task automatic model_shift(input logic [31:0] v, input int k, input int a,
                             input bit src, input bit c,
                             output logic [31:0] r, output bit co,
                             output string rtag, output string ctag);
    int n;
    n = src ? a : (a % 32);
    r = v; co = c; rtag = "R2"; ctag = "R3";
    if (n == 0) begin
      case (k)
        0, 2: begin rtag = "R4"; ctag = "R4"; end
        1: begin
          rtag = "R5"; ctag = "R5"; co = v[31];
          if (!src) r = 32'h0;
        end
        default: begin
          rtag = "R6"; ctag = "R6";
          if (!src) begin r = {c, v[31:1]}; co = v[0]; end
        end
      endcase
    end else begin
      case (k)
        0: begin
          for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? v[i - n] : 1'b0;
          co = (n <= 32) ? v[32 - n] : 1'b0;
          if (n >= 32) begin rtag = "R8"; ctag = "R8"; end
        end
        1: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i + n] : 1'b0;
          co = (n <= 32) ? v[n - 1] : 1'b0;
          if (n >= 32) begin rtag = "R8"; ctag = "R8"; end
        end
        2: begin
          for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i + n] : v[31];
          co = (n >= 32) ? v[31] : v[n - 1];
          if (n >= 32) begin rtag = "R9"; ctag = "R9"; end
        end
        default: begin
          for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
          co = v[(n - 1) % 32];
          if (n >= 32) begin rtag = "R10"; ctag = "R10"; end
        end
      endcase
    end
    if (!src && a >= 32) begin rtag = "R7"; ctag = "R7"; end
  endtask

  task automatic model_imm(input logic [7:0] b, input int rot, input bit c,
                           output logic [31:0] r, output bit co);
    logic [31:0] base;
    base = {24'h0, b};
    for (int i = 0; i < 32; i++) r[i] = base[(i + 2 * rot) % 32];
    co = (rot == 0) ? c : r[31];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [4];
    logic [31:0] er;
    bit ec;
    string rt, ct;
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'h5A3C_F069;

    // R1: inputs busy during reset, outputs must stay clear
    @(negedge clk);
    opnd_i = 32'hFFFF_FFFF; carry_i = 1'b1; kind_i = 2'd3; amt_i = 8'd5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result_o == 32'h0, "R1", "reset result", result_o, 32'h0);
    check(carry_o == 1'b0, "R1", "reset carry", {31'h0, carry_o}, 32'h0);
    rst = 1'b0;
    // R1: one clock from inputs to outputs (ROR 5 of all ones)
    @(posedge clk);
    @(negedge clk);
    check(result_o == 32'hFFFF_FFFF && carry_o, "R1", "first result",
          result_o, 32'hFFFF_FFFF);

    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 256; a++)
          for (int p = 0; p < 4; p++) begin
            imm_mode_i = 1'b0;
            opnd_i = pats[p];
            kind_i = 2'(k);
            amt_i = 8'(a);
            amt_from_reg_i = s[0];
            carry_i = 1'((p + a / 3) & 1);
            imm_byte_i = 8'(a ^ 8'h3C);
            imm_rot_i = 4'(a);
            model_shift(pats[p], k, a, s[0], carry_i, er, ec, rt, ct);
            @(posedge clk);
            @(negedge clk);
            check(result_o == er, rt, "shift result", result_o, er);
            check(carry_o == ec, ct, "shift carry", {31'h0, carry_o}, {31'h0, ec});
          end

    // R11: immediate expansion, shift inputs set to unrelated values
    for (int rot = 0; rot < 16; rot++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 2; c++) begin
          imm_mode_i = 1'b1;
          imm_rot_i = 4'(rot);
          imm_byte_i = (b == 0) ? 8'h81 : (b == 1) ? 8'hFF : (b == 2) ? 8'h01 : 8'h6C;
          carry_i = c[0];
          opnd_i = pats[b];
          kind_i = 2'(rot);
          amt_i = 8'(rot * 7);
          amt_from_reg_i = rot[0];
          model_imm(imm_byte_i, rot, c[0], er, ec);
          @(posedge clk);
          @(negedge clk);
          check(result_o == er, "R11", "imm result", result_o, er);
          check(carry_o == ec, "R11", "imm carry", {31'h0, carry_o}, {31'h0, ec});
        end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule